// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a processor may perform an I/O port access of 1, 2 or 4 bytes. It takes the current mode state, meaning the protected-mode enable, the virtual-8086 flag, the current and I/O privilege levels, and the cached task-register descriptor (valid bit, type, base, limit). It also takes the port number and the access length. From these it returns a single verdict: allow, or deny as a general-protection fault with error code zero.

When privilege alone decides the access, the verdict comes one cycle after the request and no memory is touched. When the task-state segment's permission bitmap has to be consulted, the block makes two 16-bit reads through a request/valid memory port. The first fetches the bitmap offset stored in the segment. The second fetches the bitmap word that covers the port. The second read is a full 16-bit word, so an access whose permission bits cross a byte boundary is still tested with a single length-wide mask.

Top module: `io_perm_check`

## Requirements
- R1: After reset, done_o, allow_o, fault_o and mem_req_o are all low.
- R2: When pe_i is 0, or vm_i is 0 and cpl_i is less than or equal to iopl_i, the access is allowed. done_o and allow_o are high in the cycle after start_i is sampled, and no memory read is made.
- R3: When the bitmap must be consulted and either tr_valid_i is 0 or tr_type_i is neither 4'h9 (available 32-bit segment) nor 4'hB (busy 32-bit segment), the access is denied one cycle after start with no memory read.
- R4: When the bitmap must be consulted and tr_limit_i is below 103, the access is denied one cycle after start with no memory read.
- R5: The first read is at tr_base_i + 102. mem_req_o and mem_addr_o hold steady until a cycle with mem_valid_i high.
- R6: If the returned bitmap offset plus port_i[15:3] is greater than or equal to tr_limit_i (compared at 32 bits), the access is denied after that single read.
- R7: Otherwise a second read is made at tr_base_i + bitmap offset + port_i[15:3], computed modulo 2^32.
- R8: Let w be the second word shifted right by port_i[2:0]. The access is denied if any of the low len_i bits of w is set, and allowed otherwise. len_i carries the byte count 1, 2 or 4.
- R9: done_o is a one-cycle pulse. While it is high, exactly one of allow_o and fault_o is high. start_i is ignored while a check is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a check; sampled only when idle |
| pe_i | input | 1 | Protected mode enabled |
| vm_i | input | 1 | Virtual-8086 flag |
| cpl_i | input | 2 | Current privilege level |
| iopl_i | input | 2 | I/O privilege level |
| tr_valid_i | input | 1 | Task-register cache valid |
| tr_type_i | input | 4 | Task-register descriptor type |
| tr_base_i | input | 32 | Task-state segment base address |
| tr_limit_i | input | 32 | Task-state segment scaled limit |
| port_i | input | 16 | I/O port number |
| len_i | input | 3 | Access length in bytes (1, 2 or 4) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_valid_i | input | 1 | Read data valid, completes the request |
| mem_rdata_i | input | 16 | Read data word |
| done_o | output | 1 | Verdict pulse |
| allow_o | output | 1 | Access permitted (with done_o) |
| fault_o | output | 1 | General-protection fault, error code 0 (with done_o) |

## Verification
The bench aims at the edges of the privilege test: cpl equal to iopl, and the virtual-8086 flag forcing the bitmap path at level 0. A design that flipped either comparison would read memory when it should not, or allow where it should deny. It places the bitmap offset plus port byte exactly on the limit and one below it, so an off-by-one comparison shows up as a missing or extra read. It also places the segment near the top of the address space, so that carry-limited arithmetic produces the wrong read address. Directed words put set bits just inside and just outside a window that crosses a byte boundary, which catches a mask built from bytes or from the wrong length. A start held high through a whole check exposes a design that starts a second check before the first one ends.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BASE,
    ST_MAP,
    ST_DONE
  } chk_state_e;

  localparam int unsigned MAP_PTR_OFS   = 102;
  localparam int unsigned MIN_TSS_LIMIT = 103;
  localparam int unsigned MAX_LEN_BYTES = 4;
  localparam logic [3:0]  TSS32_AVAIL   = 4'h9;
  localparam logic [3:0]  TSS32_BUSY    = 4'hB;

endpackage

// File: rtl/io_perm_gate.sv
module io_perm_gate
  import io_perm_pkg::*;
#(
  parameter int PL_W   = 2,
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 32
) (
  input  logic              pe_i,
  input  logic              vm_i,
  input  logic [PL_W-1:0]   cpl_i,
  input  logic [PL_W-1:0]   iopl_i,
  input  logic              tr_valid_i,
  input  logic [TYPE_W-1:0] tr_type_i,
  input  logic [ADDR_W-1:0] tr_limit_i,
  output logic              need_map_o,
  output logic              tss_ok_o
);

  logic type_ok;
  logic limit_ok;

  assign need_map_o = pe_i & (vm_i | (cpl_i > iopl_i));
  assign type_ok    = (tr_type_i == TYPE_W'(TSS32_AVAIL)) |
                      (tr_type_i == TYPE_W'(TSS32_BUSY));
  assign limit_ok   = (tr_limit_i >= ADDR_W'(MIN_TSS_LIMIT));
  assign tss_ok_o   = tr_valid_i & type_ok & limit_ok;

endmodule

// File: rtl/io_perm_mask.sv
module io_perm_mask
  import io_perm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 3
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [2:0]        bit_idx_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              deny_o
);

  localparam int NB = MAX_LEN_BYTES;

  logic [DATA_W-1:0] window;
  logic [NB-1:0]     len_mask;

  assign window = word_i >> bit_idx_i;

  for (genvar g = 0; g < NB; g++) begin : g_mask
    assign len_mask[g] = (len_i > LEN_W'(g));
  end

  assign deny_o = |(window[NB-1:0] & len_mask);

endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
  import io_perm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int PORT_W = 16,
  parameter int PL_W   = 2,
  parameter int TYPE_W = 4,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pe_i,
  input  logic              vm_i,
  input  logic [PL_W-1:0]   cpl_i,
  input  logic [PL_W-1:0]   iopl_i,
  input  logic              tr_valid_i,
  input  logic [TYPE_W-1:0] tr_type_i,
  input  logic [ADDR_W-1:0] tr_base_i,
  input  logic [ADDR_W-1:0] tr_limit_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              allow_o,
  output logic              fault_o
);

  chk_state_e        state_q;
  logic [PORT_W-1:0] port_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] limit_q;
  logic [ADDR_W-1:0] addr_q;
  logic              allow_q;
  logic              fault_q;

  logic              need_map;
  logic              tss_ok;
  logic              map_deny;
  logic [ADDR_W-1:0] byte_ofs;
  logic [ADDR_W-1:0] map_end;
  logic [ADDR_W-1:0] map_addr;
  logic              limit_hit;

  io_perm_gate #(.PL_W(PL_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) u_gate (
    .pe_i       (pe_i),
    .vm_i       (vm_i),
    .cpl_i      (cpl_i),
    .iopl_i     (iopl_i),
    .tr_valid_i (tr_valid_i),
    .tr_type_i  (tr_type_i),
    .tr_limit_i (tr_limit_i),
    .need_map_o (need_map),
    .tss_ok_o   (tss_ok)
  );

  io_perm_mask #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_mask (
    .word_i    (mem_rdata_i),
    .bit_idx_i (port_q[2:0]),
    .len_i     (len_q),
    .deny_o    (map_deny)
  );

  // offset of the bitmap byte holding the port, relative to the bitmap start
  assign byte_ofs  = ADDR_W'(port_q[PORT_W-1:3]);
  assign map_end   = ADDR_W'(mem_rdata_i) + byte_ofs;
  assign limit_hit = (map_end >= limit_q);
  assign map_addr  = base_q + map_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      port_q  <= '0;
      len_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
      addr_q  <= '0;
      allow_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            port_q  <= port_i;
            len_q   <= len_i;
            base_q  <= tr_base_i;
            limit_q <= tr_limit_i;
            if (!need_map) begin
              allow_q <= 1'b1;
              state_q <= ST_DONE;
            end else if (!tss_ok) begin
              fault_q <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              addr_q  <= tr_base_i + ADDR_W'(MAP_PTR_OFS);
              state_q <= ST_BASE;
            end
          end
        end
        ST_BASE: begin
          if (mem_valid_i) begin
            if (limit_hit) begin
              fault_q <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              addr_q  <= map_addr;
              state_q <= ST_MAP;
            end
          end
        end
        ST_MAP: begin
          if (mem_valid_i) begin
            allow_q <= ~map_deny;
            fault_q <= map_deny;
            state_q <= ST_DONE;
          end
        end
        default: begin
          allow_q <= 1'b0;
          fault_q <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_BASE) || (state_q == ST_MAP);
  assign mem_addr_o = addr_q;
  assign done_o     = (state_q == ST_DONE);
  assign allow_o    = allow_q;
  assign fault_o    = fault_q;

  assert_fast_allow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !need_map) |=> (done_o && allow_o && !mem_req_o));

  assert_bad_tss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && need_map && !tss_ok) |=> (done_o && fault_o));

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_limit_deny_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BASE && mem_valid_i && limit_hit) |=> (done_o && fault_o));

  assert_map_verdict_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MAP && mem_valid_i) |=> (done_o && (fault_o == $past(map_deny))));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_one_verdict_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (allow_o ^ fault_o));

  assert_quiet_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!allow_o && !fault_o));

endmodule

// File: tb/tb_io_perm_check.sv
module tb_io_perm_check;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pe = 1'b0, vm = 1'b0, trv = 1'b0;
  logic [1:0]  cpl = '0, iopl = '0;
  logic [3:0]  trt = '0;
  logic [31:0] trb = '0, trl = '0;
  logic [15:0] prt = '0;
  logic [2:0]  ln = 3'd1;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        mem_req, done, allow, fault;
  logic [31:0] mem_addr;

  // memory model state
  logic [15:0] io_base_v = '0;
  logic        ovr_en = 1'b0;
  logic [31:0] ovr_addr = '0;
  logic [15:0] ovr_word = '0;
  logic [31:0] salt = '0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [2];
  int          lat_cnt = 0;
  int          lat_tgt = 0;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_perm_check dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pe_i(pe), .vm_i(vm), .cpl_i(cpl), .iopl_i(iopl),
    .tr_valid_i(trv), .tr_type_i(trt), .tr_base_i(trb), .tr_limit_i(trl),
    .port_i(prt), .len_i(ln),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
    .done_o(done), .allow_o(allow), .fault_o(fault)
  );

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    if (a == trb + 32'd102) return io_base_v;
    if (ovr_en && a == ovr_addr) return ovr_word;
    h = (a ^ salt) * 32'h9E3779B1;
    return h[31:16] & h[15:0] & h[23:8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 1'b0;
    end else if (mem_req) begin
      if (lat_cnt >= lat_tgt) begin
        mem_valid = 1'b1;
        mem_rdata = mem_word(mem_addr);
        if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
        rd_cnt++;
        lat_cnt = 0;
        lat_tgt = $urandom % 3;
      end else begin
        lat_cnt++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "R9", "watchdog", 32'(cycles), 32'd150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  // expected verdict, number of reads and read addresses
  task automatic model(output bit e_allow, output int e_n,
                       output logic [31:0] e_a0, output logic [31:0] e_a1);
    logic [15:0] ib, w, sh;
    logic [15:0] m;
    e_a0 = '0; e_a1 = '0; e_n = 0;
    if (!(pe && (vm || cpl > iopl))) begin
      e_allow = 1'b1;
    end else if (!trv || (trt != 4'h9 && trt != 4'hB) || trl < 32'd103) begin
      e_allow = 1'b0;
    end else begin
      e_a0 = trb + 32'd102;
      ib = mem_word(e_a0);
      e_n = 1;
      if ({16'b0, ib} + {19'b0, prt[15:3]} >= trl) begin
        e_allow = 1'b0;
      end else begin
        e_a1 = trb + {16'b0, ib} + {19'b0, prt[15:3]};
        e_n = 2;
        w = mem_word(e_a1);
        sh = w >> prt[2:0];
        m = (16'd1 << ln) - 16'd1;
        e_allow = ((sh & m) == 16'd0);
      end
    end
  endtask

  task automatic run_txn(input string req, input bit hold);
    bit e_allow;
    int e_n;
    logic [31:0] e_a0, e_a1;
    int cyc;
    bit seen;
    bit g_allow, g_fault;
    int extra;
    model(e_allow, e_n, e_a0, e_a1);
    @(negedge clk);
    rd_cnt = 0;
    start = 1'b1;
    cyc = 0; seen = 0; g_allow = 0; g_fault = 0; extra = 0;
    while (!seen && cyc < 40) begin
      @(negedge clk);
      if (!hold) start = 1'b0;
      cyc++;
      if (done) begin
        seen = 1; g_allow = allow; g_fault = fault;
      end
    end
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done || allow || fault) extra++;
    end
    chk(seen, req, "done seen", 32'(seen), 32'd1);
    chk(g_allow == e_allow, req, "allow", 32'(g_allow), 32'(e_allow));
    chk(g_fault == !e_allow, req, "fault", 32'(g_fault), 32'(!e_allow));
    chk(rd_cnt == e_n, req, "reads", 32'(rd_cnt), 32'(e_n));
    chk(extra == 0, "R9", "single pulse", 32'(extra), 32'd0);
    if (e_n == 0) chk(cyc == 1, req, "latency", 32'(cyc), 32'd1);
    if (e_n >= 1 && rd_cnt >= 1) chk(rd_addr[0] == e_a0, "R5", "base addr", rd_addr[0], e_a0);
    if (e_n == 2 && rd_cnt == 2) chk(rd_addr[1] == e_a1, "R7", "map addr", rd_addr[1], e_a1);
  endtask

  task automatic set_ctx(input logic p, input logic v, input logic [1:0] c,
                         input logic [1:0] io, input logic tv, input logic [3:0] tt,
                         input logic [31:0] b, input logic [31:0] l, input logic [15:0] ib,
                         input logic [15:0] po, input logic [2:0] le);
    pe = p; vm = v; cpl = c; iopl = io; trv = tv; trt = tt;
    trb = b; trl = l; io_base_v = ib; prt = po; ln = le;
  endtask

  initial begin
    void'($urandom(32'h1F0C));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !allow && !fault && !mem_req, "R1", "reset outputs",
        {28'b0, done, allow, fault, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req, "R1", "idle after reset", {30'b0, done, mem_req}, 32'd0);

    salt = 32'h5A5A1234;
    // R2 privilege paths
    set_ctx(0, 0, 2'd3, 2'd0, 1, 4'h9, 32'h1000, 32'h2000, 16'h68, 16'h0060, 3'd1);
    run_txn("R2", 0);
    set_ctx(1, 0, 2'd1, 2'd2, 1, 4'h9, 32'h1000, 32'h2000, 16'h68, 16'h0060, 3'd2);
    run_txn("R2", 0);
    set_ctx(1, 0, 2'd3, 2'd3, 0, 4'h0, 32'h1000, 32'h2000, 16'h68, 16'h0060, 3'd4);
    run_txn("R2", 0);
    // R3 descriptor checks
    set_ctx(1, 1, 2'd0, 2'd3, 0, 4'h9, 32'h1000, 32'h2000, 16'h68, 16'h0060, 3'd1);
    run_txn("R3", 0);
    set_ctx(1, 0, 2'd3, 2'd0, 1, 4'h3, 32'h1000, 32'h2000, 16'h68, 16'h0060, 3'd1);
    run_txn("R3", 0);
    // R4 limit floor
    set_ctx(1, 1, 2'd3, 2'd3, 1, 4'hB, 32'h1000, 32'd102, 16'h60, 16'h0000, 3'd1);
    run_txn("R4", 0);
    ovr_en = 1; ovr_addr = 32'h1060; ovr_word = 16'h0000;
    set_ctx(1, 1, 2'd3, 2'd3, 1, 4'hB, 32'h1000, 32'd103, 16'h60, 16'h0000, 3'd1);
    run_txn("R4", 0);
    // R6 boundary of bitmap end
    ovr_addr = 32'h2078;
    set_ctx(1, 0, 2'd3, 2'd0, 1, 4'h9, 32'h2000, 32'h78, 16'h70, 16'h0040, 3'd1);
    run_txn("R6", 0);
    set_ctx(1, 0, 2'd3, 2'd0, 1, 4'h9, 32'h2000, 32'h79, 16'h70, 16'h0040, 3'd1);
    run_txn("R6", 0);
    // R7 address wrap
    ovr_addr = 32'h0000_0068;
    set_ctx(1, 0, 2'd3, 2'd0, 1, 4'h9, 32'hFFFF_FFF0, 32'h1000, 16'h68, 16'h0080, 3'd4);
    run_txn("R7", 0);
    // R8 window straddling a byte boundary (bit index 6)
    ovr_addr = 32'h1107; ovr_word = 16'h0200;
    set_ctx(1, 0, 2'd3, 2'd0, 1, 4'h9, 32'h1000, 32'h2000, 16'h88, 16'h03FE, 3'd4);
    run_txn("R8", 0);
    ovr_word = 16'h0420;
    run_txn("R8", 0);
    ovr_word = 16'h0100; ln = 3'd2;
    run_txn("R8", 0);
    ovr_word = 16'h0080; ln = 3'd1;
    run_txn("R8", 0);
    // R9 start held through a whole check
    ovr_word = 16'h0000; ln = 3'd4;
    run_txn("R9", 1);
    ovr_en = 0;

    for (int i = 0; i < 400; i++) begin
      int r;
      string tag;
      salt = $urandom;
      pe = ($urandom % 10) != 0;
      vm = ($urandom % 4) == 0;
      cpl = 2'($urandom); iopl = 2'($urandom);
      trv = ($urandom % 10) != 0;
      r = $urandom % 5;
      trt = (r == 0) ? 4'($urandom) : (r < 3) ? 4'h9 : 4'hB;
      trb = $urandom;
      io_base_v = 16'($urandom);
      prt = 16'($urandom);
      r = $urandom % 3;
      ln = (r == 0) ? 3'd1 : (r == 1) ? 3'd2 : 3'd4;
      r = $urandom % 10;
      if (r == 0) trl = $urandom % 110;
      else if (r < 3) trl = {16'b0, io_base_v} + {19'b0, prt[15:3]} + ($urandom % 5) - 32'd2;
      else trl = {16'b0, io_base_v} + {19'b0, prt[15:3]} + 32'd2 + ($urandom % 200);
      if (!(pe && (vm || cpl > iopl))) tag = "R2";
      else if (!trv || (trt != 4'h9 && trt != 4'hB)) tag = "R3";
      else if (trl < 32'd103) tag = "R4";
      else if ({16'b0, io_base_v} + {19'b0, prt[15:3]} >= trl) tag = "R6";
      else tag = "R8";
      run_txn(tag, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule